// File: doc/BRIEF.md
# Multi-Channel DMA Request Controller

This block owns a small bank of DMA channels. Each channel holds a mode word, a remaining byte count and a start address, all written and read over a simple 32-bit register bus. A peripheral asks for a burst by naming a channel, a direction and a length. The block accepts the request and checks it against the channel's enable bit and programmed direction.

A request that passes the check becomes a single memory command. The command carries the channel's start address, the length clipped to the remaining count, and the direction. The command stays up until the memory side returns a done strobe. The channel's count then drops by the moved length and its terminal-count flag sets. A request that fails the check moves nothing. It sets the channel's memory-error flag and a bit in a shared error-source register, and any set bit of that register drives the error interrupt. Only one request is serviced at a time. While a burst is in flight, a ready/valid handshake holds new requests off.

The reset input is asynchronous and active-low. Its release is synchronised inside the block, so the block leaves reset two clock edges after `rst_n` rises.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, every channel register and the error-source register read zero, `req_ready` is 1, `mem_cmd_valid` is 0 and `err_irq` is 0.
- R2: Channel n occupies a 32-byte window at byte offset 0x100 + 0x20·n. The mode register is at +0x08, the count register at +0x10 and the address register at +0x18. All 32 bits are written and read back. Offset +0x00 of a window reads zero, and bus address bits [2:0] are ignored.
- R3: In the mode register, bit 0 enables the channel and bit 1 set means memory-to-device. A request is accepted on a rising clock edge where `req_valid` and `req_ready` are both 1. If the channel is enabled and `req_to_dev` equals mode bit 1, then `mem_cmd_valid` is 1 from the next cycle, with `mem_addr` equal to the channel's address register and `mem_to_dev` equal to `req_to_dev`.
- R4: `mem_len` is the smaller of `req_len` and the channel's count register at acceptance.
- R5: `mem_cmd_valid` stays high, with stable outputs, until a clock edge where `mem_done` is 1. After that edge the channel's mode bit 8 (terminal count) is set, its count has dropped by `mem_len`, and `req_ready` is 1 again.
- R6: A request to a channel whose mode bit 0 is clear issues no command. It sets mode bit 9 (memory error) and bit n of the error-source register.
- R7: A request whose `req_to_dev` differs from mode bit 1 is handled exactly as in R6.
- R8: Every accepted request first clears mode bits 10:8 of its channel, before that request's own outcome flag is set.
- R9: While a command is outstanding, `req_ready` is 0 and `req_valid` has no effect on any register or output.
- R10: The error-source register reads at offset 0x080, with bit n belonging to channel n. Writing 1 to a bit clears it. An error set in the same cycle as a clear wins. `err_irq` is 1 exactly when any bit of this register is set.
- R11: `mem_done` while no command is outstanding changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Register byte address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from `bus_addr` |
| req_valid | input | 1 | Peripheral burst request |
| req_ready | output | 1 | Block can accept a request |
| req_chan | input | 2 | Requested channel |
| req_to_dev | input | 1 | 1 = memory-to-device, 0 = device-to-memory |
| req_len | input | 32 | Requested burst length in bytes |
| mem_cmd_valid | output | 1 | Memory command outstanding |
| mem_addr | output | 32 | Command start address |
| mem_len | output | 32 | Command length in bytes |
| mem_to_dev | output | 1 | Command direction |
| mem_done | input | 1 | Memory side finished the command |
| err_irq | output | 1 | Any error-source bit set |

## Verification
Every result of this block is due one clock edge after the stimulus that causes it. An accepted request shows its command or its error flag and source bit after the acceptance edge. A done strobe shows the new count, the terminal-count flag and `req_ready` after the edge that samples it. A W1C write shows after its write edge. The bench drives inputs on the falling edge. It updates a behavioural model on each rising edge and compares all registered outputs 1 ns later, so every comparison falls in the cycle where the result first appears. Register contents are read back combinationally between edges, against both the model and fixed expected values for each named case.

// File: rtl/dma_cc_pkg.sv
package dma_cc_pkg;
  // mode register bit positions (decoded by the request engine)
  localparam int unsigned MODE_EN_BIT  = 0;
  localparam int unsigned MODE_M2D_BIT = 1;
  localparam int unsigned FLG_TC_BIT   = 8;
  localparam int unsigned FLG_MEM_BIT  = 9;
  localparam int unsigned FLG_ADR_BIT  = 10;

  // register map
  localparam logic [11:0] SRC_OFFSET = 12'h080;
  localparam logic [3:0]  CH_PAGE    = 4'h1;   // bus_addr[11:8] of channel windows
  localparam logic [1:0]  IDX_MODE   = 2'd1;
  localparam logic [1:0]  IDX_COUNT  = 2'd2;
  localparam logic [1:0]  IDX_ADDR   = 2'd3;

  typedef enum logic {ST_IDLE, ST_BUSY} eng_state_t;
endpackage

// File: rtl/dcc_chan_regs.sv
module dcc_chan_regs
  import dma_cc_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          wr_mode,
  input  logic          wr_count,
  input  logic          wr_addr,
  input  logic [DW-1:0] wdata,
  input  logic          eng_clr,
  input  logic          eng_err,
  input  logic          eng_done,
  input  logic [DW-1:0] eng_len,
  output logic [DW-1:0] mode_o,
  output logic [DW-1:0] count_o,
  output logic [DW-1:0] addr_o
);
  logic [DW-1:0] mode_q, mode_d, count_q, count_d, addr_q, addr_d;
  logic          mode_en, count_en, addr_en;

  // next state: bus write first, then the engine's update on top
  always_comb begin
    mode_d  = mode_q;
    count_d = count_q;
    addr_d  = addr_q;
    if (wr_mode)  mode_d  = wdata;
    if (wr_count) count_d = wdata;
    if (wr_addr)  addr_d  = wdata;
    if (eng_clr) begin
      mode_d[FLG_TC_BIT]  = 1'b0;
      mode_d[FLG_MEM_BIT] = 1'b0;
      mode_d[FLG_ADR_BIT] = 1'b0;
    end
    if (eng_err)  mode_d[FLG_MEM_BIT] = 1'b1;
    if (eng_done) begin
      mode_d[FLG_TC_BIT] = 1'b1;
      count_d            = count_q - eng_len;
    end
  end

  assign mode_en  = wr_mode | eng_clr | eng_err | eng_done;
  assign count_en = wr_count | eng_done;
  assign addr_en  = wr_addr;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      count_q <= '0;
      addr_q  <= '0;
    end else begin
      if (mode_en)  mode_q  <= mode_d;
      if (count_en) count_q <= count_d;
      if (addr_en)  addr_q  <= addr_d;
    end
  end

  assign mode_o  = mode_q;
  assign count_o = count_q;
  assign addr_o  = addr_q;

  // R8
  flags_cleared_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (eng_clr && !eng_err) |=> (mode_o[FLG_ADR_BIT:FLG_TC_BIT] == 3'b000));
  // R5
  count_drop_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (eng_done && !wr_count) |=> (count_o == $past(count_o) - $past(eng_len)));
endmodule

// File: rtl/dcc_req_engine.sv
module dcc_req_engine
  import dma_cc_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DW     = 32,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic                       clk,
  input  logic                       rst_ni,
  input  logic                       req_valid,
  input  logic [CH_W-1:0]            req_chan,
  input  logic                       req_to_dev,
  input  logic [DW-1:0]              req_len,
  input  logic [NUM_CH-1:0][DW-1:0]  mode_i,
  input  logic [NUM_CH-1:0][DW-1:0]  count_i,
  input  logic [NUM_CH-1:0][DW-1:0]  addr_i,
  input  logic                       mem_done,
  input  logic                       src_clr_we,
  input  logic [NUM_CH-1:0]          src_clr_mask,
  output logic                       req_ready,
  output logic                       mem_cmd_valid,
  output logic [DW-1:0]              mem_addr,
  output logic [DW-1:0]              mem_len,
  output logic                       mem_to_dev,
  output logic [NUM_CH-1:0]          clr_vec,
  output logic [NUM_CH-1:0]          err_vec,
  output logic [NUM_CH-1:0]          done_vec,
  output logic [DW-1:0]              done_len,
  output logic [NUM_CH-1:0]          src_o,
  output logic                       err_irq
);
  localparam logic [NUM_CH-1:0] ONE = {{(NUM_CH-1){1'b0}}, 1'b1};

  eng_state_t        state_q, state_d;
  logic [CH_W-1:0]   ch_q, ch_d;
  logic [DW-1:0]     len_q, len_d, adr_q, adr_d;
  logic              dir_q, dir_d;
  logic [NUM_CH-1:0] src_q, src_d;
  logic              accept, bad, finish, cmd_en;
  logic [DW-1:0]     sel_mode, sel_count, fit_len;
  logic [NUM_CH-1:0] req_oh;

  assign sel_mode  = mode_i[req_chan];
  assign sel_count = count_i[req_chan];
  assign accept    = req_valid && (state_q == ST_IDLE);
  assign bad       = !sel_mode[MODE_EN_BIT] || (sel_mode[MODE_M2D_BIT] != req_to_dev);
  assign fit_len   = (req_len > sel_count) ? sel_count : req_len;
  assign finish    = (state_q == ST_BUSY) && mem_done;
  assign req_oh    = ONE << req_chan;

  assign clr_vec  = accept ? req_oh : '0;
  assign err_vec  = (accept && bad) ? req_oh : '0;
  assign done_vec = finish ? (ONE << ch_q) : '0;
  assign done_len = len_q;

  always_comb begin
    state_d = state_q;
    ch_d    = ch_q;
    len_d   = len_q;
    adr_d   = adr_q;
    dir_d   = dir_q;
    if (accept && !bad) begin
      state_d = ST_BUSY;
      ch_d    = req_chan;
      len_d   = fit_len;
      adr_d   = addr_i[req_chan];
      dir_d   = req_to_dev;
    end else if (finish) begin
      state_d = ST_IDLE;
    end
    src_d = (src_q & ~(src_clr_we ? src_clr_mask : '0)) | err_vec;
  end

  assign cmd_en = accept && !bad;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
      len_q   <= '0;
      adr_q   <= '0;
      dir_q   <= 1'b0;
      src_q   <= '0;
    end else begin
      state_q <= state_d;
      src_q   <= src_d;
      if (cmd_en) begin
        ch_q  <= ch_d;
        len_q <= len_d;
        adr_q <= adr_d;
        dir_q <= dir_d;
      end
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_cmd_valid = (state_q == ST_BUSY);
  assign mem_addr      = adr_q;
  assign mem_len       = len_q;
  assign mem_to_dev    = dir_q;
  assign src_o         = src_q;
  assign err_irq       = |src_q;

  // R3
  good_req_cmd_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (accept && !bad) |=> (mem_cmd_valid && mem_to_dev == $past(req_to_dev)));
  // R4
  len_clip_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (accept && !bad) |=> (mem_len <= $past(req_len) && mem_len <= $past(sel_count)));
  // R5
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_cmd_valid && mem_done) |=> req_ready);
  // R6
  bad_req_irq_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (accept && bad) |=> (err_irq && !mem_cmd_valid));
  // R9
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_cmd_valid && !mem_done) |=> (mem_cmd_valid && !req_ready && $stable(mem_addr) && $stable(mem_len)));
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_cc_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DW     = 32,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [11:0]     bus_addr,
  input  logic            bus_wr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [CH_W-1:0] req_chan,
  input  logic            req_to_dev,
  input  logic [DW-1:0]   req_len,
  output logic            mem_cmd_valid,
  output logic [DW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_len,
  output logic            mem_to_dev,
  input  logic            mem_done,
  output logic            err_irq
);
  logic [1:0] rst_pipe;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  logic                      chan_hit, src_hit;
  logic [2:0]                win_idx;
  logic [1:0]                reg_idx;
  logic [NUM_CH-1:0][DW-1:0] mode_arr, count_arr, addr_arr;
  logic [NUM_CH-1:0]         clr_vec, err_vec, done_vec, src_vec;
  logic [DW-1:0]             done_len;

  assign chan_hit = (bus_addr[11:8] == CH_PAGE);
  assign src_hit  = (bus_addr[11:3] == SRC_OFFSET[11:3]);
  assign win_idx  = bus_addr[7:5];
  assign reg_idx  = bus_addr[4:3];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic sel;
    assign sel = bus_wr && chan_hit && (win_idx == 3'(g));
    dcc_chan_regs #(.DW(DW)) u_regs (
      .clk      (clk),
      .rst_ni   (rst_ni),
      .wr_mode  (sel && reg_idx == IDX_MODE),
      .wr_count (sel && reg_idx == IDX_COUNT),
      .wr_addr  (sel && reg_idx == IDX_ADDR),
      .wdata    (bus_wdata),
      .eng_clr  (clr_vec[g]),
      .eng_err  (err_vec[g]),
      .eng_done (done_vec[g]),
      .eng_len  (done_len),
      .mode_o   (mode_arr[g]),
      .count_o  (count_arr[g]),
      .addr_o   (addr_arr[g])
    );
  end

  dcc_req_engine #(.NUM_CH(NUM_CH), .DW(DW)) u_eng (
    .clk           (clk),
    .rst_ni        (rst_ni),
    .req_valid     (req_valid),
    .req_chan      (req_chan),
    .req_to_dev    (req_to_dev),
    .req_len       (req_len),
    .mode_i        (mode_arr),
    .count_i       (count_arr),
    .addr_i        (addr_arr),
    .mem_done      (mem_done),
    .src_clr_we    (bus_wr && src_hit),
    .src_clr_mask  (bus_wdata[NUM_CH-1:0]),
    .req_ready     (req_ready),
    .mem_cmd_valid (mem_cmd_valid),
    .mem_addr      (mem_addr),
    .mem_len       (mem_len),
    .mem_to_dev    (mem_to_dev),
    .clr_vec       (clr_vec),
    .err_vec       (err_vec),
    .done_vec      (done_vec),
    .done_len      (done_len),
    .src_o         (src_vec),
    .err_irq       (err_irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (src_hit) begin
      bus_rdata = DW'(src_vec);
    end else if (chan_hit && (int'(win_idx) < NUM_CH)) begin
      case (reg_idx)
        IDX_MODE:  bus_rdata = mode_arr[win_idx[CH_W-1:0]];
        IDX_COUNT: bus_rdata = count_arr[win_idx[CH_W-1:0]];
        IDX_ADDR:  bus_rdata = addr_arr[win_idx[CH_W-1:0]];
        default:   bus_rdata = '0;
      endcase
    end
  end

  // R10
  irq_matches_src_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (err_vec != '0) |=> (err_irq && ((src_vec & $past(err_vec)) == $past(err_vec))));
  // R11
  idle_done_ignored_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_ready && !req_valid && mem_done && !bus_wr) |=> ($stable(count_arr) && $stable(mode_arr)));
endmodule

// File: tb/dma_chan_ctrl_tb.sv
`timescale 1ns/1ps
module dma_chan_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_chan = '0;
  logic        req_to_dev = 1'b0;
  logic [31:0] req_len = '0;
  logic        mem_cmd_valid;
  logic [31:0] mem_addr, mem_len;
  logic        mem_to_dev;
  logic        mem_done = 1'b0;
  logic        err_irq;

  always #2 clk = ~clk;

  dma_chan_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_chan(req_chan), .req_to_dev(req_to_dev),
    .req_len(req_len), .mem_cmd_valid(mem_cmd_valid), .mem_addr(mem_addr),
    .mem_len(mem_len), .mem_to_dev(mem_to_dev), .mem_done(mem_done),
    .err_irq(err_irq)
  );

  int n_run = 0, n_fail = 0, cyc = 0;
  bit cmp_en = 1'b0;

  // behavioural reference model
  logic [31:0] m_mode[4], m_cnt[4], m_adr[4];
  logic [3:0]  m_src;
  bit          m_busy;
  int          m_ch;
  logic [31:0] m_len, m_cadr;
  logic        m_dir;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    logic [31:0] o_mode, o_cnt, e;
    int c;
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin m_mode[i] = 0; m_cnt[i] = 0; m_adr[i] = 0; end
      m_src = 0; m_busy = 0; m_ch = 0; m_len = 0; m_cadr = 0; m_dir = 0;
    end else begin
      c = int'(req_chan);
      o_mode = m_mode[c];
      o_cnt  = m_cnt[c];
      if (bus_wr) begin
        if (bus_addr[11:3] == 9'h010) m_src = m_src & ~bus_wdata[3:0];
        if (bus_addr[11:8] == 4'h1 && bus_addr[7:5] < 4) begin
          case (bus_addr[4:3])
            2'd1: m_mode[bus_addr[6:5]] = bus_wdata;
            2'd2: m_cnt[bus_addr[6:5]]  = bus_wdata;
            2'd3: m_adr[bus_addr[6:5]]  = bus_wdata;
            default: ;
          endcase
        end
      end
      if (m_busy) begin
        if (mem_done) begin
          m_mode[m_ch] = m_mode[m_ch] | 32'h100;
          m_cnt[m_ch]  = m_cnt[m_ch] - m_len;
          m_busy = 0;
        end
      end else if (req_valid) begin
        m_mode[c] = m_mode[c] & ~32'h700;
        if (!o_mode[0] || (o_mode[1] != req_to_dev)) begin
          m_mode[c] = m_mode[c] | 32'h200;
          m_src[c]  = 1'b1;
        end else begin
          m_busy = 1; m_ch = c; m_dir = req_to_dev;
          m_cadr = m_adr[c];
          m_len  = (req_len > o_cnt) ? o_cnt : req_len;
        end
      end
    end
    #1;
    if (cmp_en) begin
      // R3 R5 R9 R10: registered outputs against the model each cycle
      e = {29'd0, !m_busy, m_busy, m_src != 0};
      chk("R9/R10 ready,cmd,irq", {29'd0, req_ready, mem_cmd_valid, err_irq}, e);
      if (m_busy) begin
        chk("R3 mem_addr", mem_addr, m_cadr);
        chk("R4 mem_len", mem_len, m_len);
        chk("R3 mem_to_dev", {31'd0, mem_to_dev}, {31'd0, m_dir});
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      finish_up();
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk); bus_addr = a; bus_wr = 1'b0;
    #1 chk(req, bus_rdata, exp);
  endtask

  task automatic req(input int ch, input logic dir, input logic [31:0] len);
    @(negedge clk); req_valid = 1'b1; req_chan = 2'(ch); req_to_dev = dir; req_len = len;
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic done_after(input int n);
    repeat (n) @(negedge clk);
    mem_done = 1'b1;
    @(negedge clk); mem_done = 1'b0;
  endtask

  function automatic logic [11:0] ra(input int ch, input int idx);
    return 12'(32'h100 + ch * 32 + idx * 8);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cmp_en = 1'b1;
    // R1 reset state
    for (int ch = 0; ch < 4; ch++) begin
      rd("R1 mode", ra(ch, 1), 0);
      rd("R1 count", ra(ch, 2), 0);
      rd("R1 addr", ra(ch, 3), 0);
    end
    rd("R1 src", 12'h080, 0);
    // R2 programming and readback
    wr(ra(0, 1), 32'h3);  wr(ra(0, 2), 100); wr(ra(0, 3), 32'h1000_0040);
    wr(ra(1, 1), 32'h1);  wr(ra(1, 2), 8);   wr(ra(1, 3), 32'h0000_2000);
    wr(ra(2, 1), 32'h0);  wr(ra(2, 2), 50);  wr(ra(2, 3), 32'h0000_5000);
    wr(ra(3, 1), 32'h703); wr(ra(3, 2), 10); wr(ra(3, 3), 32'hDEAD_BEEF);
    rd("R2 addr ch3", ra(3, 3), 32'hDEAD_BEEF);
    rd("R2 count ch0 low bits ignored", ra(0, 2) | 12'h5, 100);
    rd("R2 window +0 reads zero", ra(1, 0), 0);
    // R3 good request, R9 request held off while busy
    req(0, 1'b1, 40);
    @(negedge clk); req_valid = 1'b1; req_chan = 2'd1; req_to_dev = 1'b0; req_len = 4;
    repeat (2) @(negedge clk); req_valid = 1'b0;
    rd("R9 ch1 count untouched", ra(1, 2), 8);
    done_after(1);
    // R5 terminal count and count drop
    rd("R5 ch0 count", ra(0, 2), 60);
    rd("R5 ch0 mode", ra(0, 1), 32'h103);
    // R4 clipped length
    req(1, 1'b0, 20);
    done_after(0);
    rd("R4 ch1 count zero", ra(1, 2), 0);
    // R6 disabled channel
    req(2, 1'b1, 5);
    rd("R6 ch2 mode", ra(2, 1), 32'h200);
    rd("R6 src", 12'h080, 32'h4);
    rd("R6 ch2 count untouched", ra(2, 2), 50);
    // R7 direction mismatch, R8 old TC cleared
    req(0, 1'b0, 5);
    rd("R7 R8 ch0 mode", ra(0, 1), 32'h203);
    rd("R7 src", 12'h080, 32'h5);
    // R8 preset flags cleared on a good request
    req(3, 1'b1, 4);
    rd("R8 ch3 mode while busy", ra(3, 1), 32'h003);
    done_after(2);
    rd("R8 ch3 mode after done", ra(3, 1), 32'h103);
    rd("R5 ch3 count", ra(3, 2), 6);
    // R11 stray done
    done_after(0);
    rd("R11 ch3 count", ra(3, 2), 6);
    rd("R11 ch3 mode", ra(3, 1), 32'h103);
    // R10 W1C and set-beats-clear
    wr(12'h080, 32'h1);
    rd("R10 src after clear", 12'h080, 32'h4);
    @(negedge clk);
    bus_addr = 12'h080; bus_wdata = 32'h4; bus_wr = 1'b1;
    req_valid = 1'b1; req_chan = 2'd2; req_to_dev = 1'b0; req_len = 1;
    @(negedge clk); bus_wr = 1'b0; req_valid = 1'b0;
    rd("R10 set wins", 12'h080, 32'h4);
    wr(12'h080, 32'hF);
    rd("R10 all cleared", 12'h080, 32'h0);
    @(negedge clk);
    chk("R10 irq low", {31'd0, err_irq}, 32'd0);
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule